// File: doc/BRIEF.md
# Port Interrupt Flag Controller

This block holds the interrupt status and enable logic for one side of a parallel port adapter. It watches two peripheral control inputs, C1 and C2. It samples both through a synchroniser and looks for a transition in the direction that software has chosen for each line. An active transition sets a sticky status flag for that line. The C1 flag is read back as control bit 7 and the C2 flag as control bit 6.

Each flag has an enable bit. The enable gates only the interrupt request, so a masked flag can still be polled. The request output tells an external open-drain pad when to pull the shared, active-low request line low. Both flags clear as a side effect of the processor reading this side's peripheral data register. A second instance serves the other side with its own request line.

The control input carries the low six bits of the side's control register. Bit 0 is the C1 request enable and bit 1 selects the C1 edge (1 = rising, 0 = falling). Bit 3 is the C2 request enable and bit 4 selects the C2 edge (1 = rising, 0 = falling). Bits 2 and 5 belong to other logic and are ignored here.

Top module: `port_irq_ctrl`

## Requirements
- R1: While reset is asserted, both flags read 0 and `irq_pull_o` is 0 (line released).
- R2: An active transition on `c1_in` sets `flag1_o`; control bit 1 selects the active edge (1 = rising, 0 = falling).
- R3: An active transition on `c2_in` sets `flag2_o`; control bit 4 selects the active edge (1 = rising, 0 = falling).
- R4: A transition in the direction not selected sets no flag.
- R5: Control bit 0 = 0 keeps `flag1_o` from driving the request, but the flag itself still sets. Setting bit 0 later while the flag is set asserts the request.
- R6: Control bit 3 = 0 keeps `flag2_o` from driving the request, but the flag itself still sets. Setting bit 3 later while the flag is set asserts the request.
- R7: `irq_pull_o` is 1 exactly when at least one flag is set with its enable bit at 1.
- R8: A one-cycle `data_rd` strobe clears both flags at the clock edge that samples it.
- R9: If an active transition would set a flag at the same edge as a clearing read, that flag stays set.
- R10: With default parameters, a flag becomes visible at the third rising clock edge after its input changes, and not earlier.
- R11: A level already present on a control input when reset is released does not set a flag.
- R12: Control bits 2 and 5 have no effect on the flags or on the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| c1_in | input | 1 | Peripheral control input C1 (asynchronous) |
| c2_in | input | 1 | Peripheral control input C2 (asynchronous, input only) |
| ctl | input | 6 | Low six bits of the control register: bit 0 C1 enable, bit 1 C1 edge, bit 3 C2 enable, bit 4 C2 edge |
| data_rd | input | 1 | One-cycle strobe marking a selected read of the peripheral data register |
| flag1_o | output | 1 | C1 status flag (control read-back bit 7) |
| flag2_o | output | 1 | C2 status flag (control read-back bit 6) |
| irq_pull_o | output | 1 | 1 = pull the open-drain request line low |

## Verification
A flag stuck in the wrong state shows directly at `flag1_o` or `flag2_o`. If its enable bit is set, it shows on `irq_pull_o` in the same cycle. A wrong edge sampler or a wrong polarity decode shows three clock edges after the stimulus, as a missing or extra flag. A broken clear priority shows one edge after the coincident read, as a flag that dropped. A bad warm-up after reset shows as a flag set without any input transition a few edges after release.

// File: rtl/pif_pkg.sv
package pif_pkg;
  localparam int unsigned LINES   = 2;
  localparam int unsigned CTL_W   = 6;
  localparam int unsigned FIELD_W = 3;
  localparam int unsigned SPARE_A = 2;
  localparam int unsigned SPARE_B = 5;

  typedef struct packed {
    logic irq_en;
    logic rise_sel;
  } line_cfg_t;

  function automatic int unsigned en_pos(int unsigned idx);
    return FIELD_W * idx;
  endfunction

  function automatic int unsigned pol_pos(int unsigned idx);
    return FIELD_W * idx + 1;
  endfunction
endpackage

// File: rtl/pif_reset_ctl.sv
module pif_reset_ctl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n,
  output logic armed
);
  localparam int unsigned WARM = SYNC_STAGES + 1;
  localparam int unsigned CW   = $clog2(WARM + 1);
  localparam logic [CW-1:0] WARM_C = CW'(WARM);

  logic [SYNC_STAGES-1:0] rs_q, rs_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   cnt_en;

  // reset release pipeline
  always_comb rs_d = {rs_q[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_d;
  end

  assign rst_sync_n = rs_q[SYNC_STAGES-1];

  // warm-up: edges are ignored until the sampler holds real data
  always_comb begin
    cnt_en = (cnt_q != WARM_C);
    cnt_d  = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cnt_q <= '0;
    else if (cnt_en)  cnt_q <= cnt_d;
  end

  assign armed = (cnt_q == WARM_C);
endmodule

// File: rtl/pif_edge_det.sv
module pif_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  input  logic rise_sel,
  input  logic armed,
  output logic hit
);
  logic [SYNC_STAGES-1:0] sy_q, sy_d;
  logic                   prev_q, prev_d;
  logic                   lvl;

  always_comb begin
    sy_d   = {sy_q[SYNC_STAGES-2:0], d_in};
    prev_d = sy_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sy_q   <= sy_d;
      prev_q <= prev_d;
    end
  end

  assign lvl = sy_q[SYNC_STAGES-1];
  assign hit = armed && (lvl != prev_q) && (lvl == rise_sel);
endmodule

// File: rtl/pif_flag.sv
module pif_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  // set takes priority over clear
  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/port_irq_ctrl.sv
module port_irq_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       c1_in,
  input  logic       c2_in,
  input  logic [5:0] ctl,
  input  logic       data_rd,
  output logic       flag1_o,
  output logic       flag2_o,
  output logic       irq_pull_o
);
  import pif_pkg::*;

  logic                   rst_sync_n;
  logic                   armed;
  logic [LINES-1:0]       line_in;
  logic [LINES-1:0]       set_vec;
  logic [LINES-1:0]       flag_vec;
  logic [LINES-1:0]       en_vec;
  line_cfg_t [LINES-1:0]  cfg;
  logic                   unused_ctl;

  assign line_in    = {c2_in, c1_in};
  assign unused_ctl = ctl[SPARE_A] ^ ctl[SPARE_B];

  pif_reset_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n),
    .armed      (armed)
  );

  for (genvar gi = 0; gi < LINES; gi++) begin : g_line
    assign cfg[gi].irq_en   = ctl[en_pos(gi)];
    assign cfg[gi].rise_sel = ctl[pol_pos(gi)];
    assign en_vec[gi]       = cfg[gi].irq_en;

    pif_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .d_in     (line_in[gi]),
      .rise_sel (cfg[gi].rise_sel),
      .armed    (armed),
      .hit      (set_vec[gi])
    );

    pif_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .set_i  (set_vec[gi]),
      .clr_i  (data_rd),
      .flag_o (flag_vec[gi])
    );
  end

  assign flag1_o    = flag_vec[0];
  assign flag2_o    = flag_vec[1];
  assign irq_pull_o = |(flag_vec & en_vec);
endmodule

// File: rtl/pif_chk.sv
module pif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] ctl,
  input logic       data_rd,
  input logic [1:0] set_vec,
  input logic       flag1_o,
  input logic       flag2_o,
  input logic       irq_pull_o
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!flag1_o && !flag2_o && !irq_pull_o)
        else $error("reset state violated");
    end
  end

  p_c1_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[0] |=> flag1_o);

  p_c2_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[1] |=> flag2_o);

  p_rise_needs_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag1_o) |-> $past(set_vec[0]));

  p_en1_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag1_o && ctl[0]) |-> irq_pull_o);

  p_en2_drives_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag2_o && ctl[3]) |-> irq_pull_o);

  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull_o |-> ((flag1_o && ctl[0]) || (flag2_o && ctl[3])));

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !set_vec[0] && !set_vec[1]) |=> (!flag1_o && !flag2_o));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && set_vec[0]) |=> flag1_o);

  p_flag_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag2_o && !data_rd) |=> flag2_o);
endmodule

bind port_irq_ctrl pif_chk i_pif_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl        (ctl),
  .data_rd    (data_rd),
  .set_vec    (set_vec),
  .flag1_o    (flag1_o),
  .flag2_o    (flag2_o),
  .irq_pull_o (irq_pull_o)
);

// File: tb/test_port_irq_ctrl.sv
module test_port_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk;
  logic       rst_n;
  logic       c1_in;
  logic       c2_in;
  logic [5:0] ctl;
  logic       data_rd;
  logic       flag1_o;
  logic       flag2_o;
  logic       irq_pull_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [2:0] exp_q[$];
  string      tag_q[$];
  event       chk_ev;

  port_irq_ctrl i_port_irq_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .c1_in      (c1_in),
    .c2_in      (c2_in),
    .ctl        (ctl),
    .data_rd    (data_rd),
    .flag1_o    (flag1_o),
    .flag2_o    (flag2_o),
    .irq_pull_o (irq_pull_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops expected {flag1, flag2, irq} and compares
  always @(chk_ev) begin
    while (exp_q.size() > 0) begin
      logic [2:0] e;
      logic [2:0] got;
      string      t;
      e   = exp_q.pop_front();
      t   = tag_q.pop_front();
      got = {flag1_o, flag2_o, irq_pull_o};
      checks++;
      if (got !== e) begin
        errors++;
        $display("FAIL %s: {flag1,flag2,irq} got %b expected %b", t, got, e);
      end
    end
  end

  task automatic expect_out(input string tag, input logic [2:0] e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    -> chk_ev;
    #1;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_pulse();
    data_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    data_rd = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    c1_in   = 1'b1;          // level held across reset release (R11)
    c2_in   = 1'b0;
    ctl     = 6'b011011;     // both enabled, both rising
    data_rd = 1'b0;
    tick(2);
    expect_out("R1", 3'b000);
    rst_n = 1'b1;
    tick(8);
    expect_out("R11", 3'b000);

    c1_in = 1'b0;            // falling while rising selected
    tick(3);
    expect_out("R4", 3'b000);
    c1_in = 1'b1;
    tick(2);
    expect_out("R10", 3'b000);
    tick(1);
    expect_out("R2", 3'b101);
    read_pulse();
    expect_out("R8", 3'b000);

    ctl = 6'b000011;         // C2 falling, C2 masked
    c2_in = 1'b1;
    tick(3);
    expect_out("R4", 3'b000);
    c2_in = 1'b0;
    tick(3);
    expect_out("R3", 3'b010);
    expect_out("R6", 3'b010);
    ctl = 6'b001011;
    tick(1);
    expect_out("R6", 3'b011);
    ctl = 6'b101111;         // spare bits toggled
    tick(2);
    expect_out("R12", 3'b011);
    ctl = 6'b001011;
    read_pulse();
    expect_out("R8", 3'b000);

    ctl = 6'b001010;         // C1 masked
    c1_in = 1'b0;
    tick(3);
    c1_in = 1'b1;
    tick(3);
    expect_out("R5", 3'b100);
    ctl = 6'b001011;
    tick(1);
    expect_out("R5", 3'b101);

    c1_in = 1'b0;
    tick(3);
    c1_in = 1'b1;            // edge lands at third edge, read at same edge
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    data_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    data_rd = 1'b0;
    expect_out("R9", 3'b101);
    read_pulse();
    expect_out("R8", 3'b000);

    c2_in = 1'b1;
    tick(3);
    c2_in = 1'b0;
    tick(3);
    c1_in = 1'b0;
    tick(3);
    c1_in = 1'b1;
    tick(3);
    expect_out("R7", 3'b111);
    read_pulse();
    expect_out("R8", 3'b000);

    done = 1'b1;
    tick(1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule